// File: doc/BRIEF.md
# Interprocessor Interrupt Command Issuer

This block is the command path of a local interrupt controller. Software fills a 64-bit interrupt command register through a 32-bit write port. The upper word holds a destination ID. A write to the lower word builds one interprocessor interrupt message and launches it. The message carries a vector, a delivery mode, a trigger mode, a destination shorthand and a destination.

A second, vector-only write port is a fast path for self-interrupts. A write there launches a message with self shorthand, edge trigger and fixed delivery. That message is bit-for-bit the same as the one a full command write with those settings would produce.

Messages leave on a valid/ready handshake. Only one message can wait at a time. A launch that arrives while a message is pending is discarded and sets a sticky error flag.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: After reset, `msg_valid_o`, `busy_o` and `err_o` are 0.
- R2: A write with `wr_en_i`=1 and `wr_addr_i`=0 (low word) makes `msg_valid_o` rise one cycle later. The message fields come from the write data: vector = bits [7:0], delivery mode = bits [10:8] (000 = fixed), trigger = bit 15 (0 = edge), shorthand = bits [19:18] (00 = none, 01 = self, 10 = all including self, 11 = all excluding self).
- R3: A write with `wr_addr_i`=1 (high word) launches no message. It stores bits [31:24] as the destination used by later low-word writes.
- R4: `msg_dest_o` equals the stored high-word bits [31:24] when the shorthand is 00. It is 0 for any other shorthand.
- R5: A write on `self_we_i` launches a message one cycle later with vector = `self_data_i`[7:0], shorthand 01, trigger 0, delivery mode 000 and destination 0. All other bits of `self_data_i` are ignored.
- R6: While `msg_valid_o`=1 and `msg_ready_i`=0, valid stays 1 and every message field stays unchanged. After a cycle with valid and ready both 1, valid is 0 unless a new launch was taken.
- R7: `busy_o` equals `msg_valid_o`. A launch in any cycle where `busy_o`=1 is dropped, and this includes the handshake cycle. A dropped launch sets `err_o`, which then stays 1 until reset.
- R8: If a low-word command write and a self write arrive in the same cycle, only the command message is launched. The self write is discarded without setting `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Command register write strobe |
| wr_addr_i | input | 1 | Word select: 0 = low, 1 = high |
| wr_data_i | input | 32 | Command register write data |
| self_we_i | input | 1 | Self-interrupt register write strobe |
| self_data_i | input | 32 | Self-interrupt write data (only [7:0] used) |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by transport |
| msg_vector_o | output | 8 | Message vector |
| msg_dmode_o | output | 3 | Delivery mode |
| msg_trig_o | output | 1 | Trigger mode (0 = edge) |
| msg_short_o | output | 2 | Destination shorthand |
| msg_dest_o | output | 8 | Destination ID |
| busy_o | output | 1 | Delivery pending |
| err_o | output | 1 | Sticky dropped-launch flag |

## Verification
The assertions assume that reset is asserted at the start and that the write strobes and ready input are never X after reset. They do not assume anything about how ready relates to valid, so ready may be low for any number of cycles or high while nothing is pending.

The stimulus changes every input half a cycle away from the sampling edge. It exercises both a steadily high ready and long stretches of low ready, with launches issued into the busy window on purpose. Same-cycle collisions of the command and self ports are issued only while the output is idle, so the priority rule is observed apart from the drop rule.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned DMODE_W   = 3;
  localparam int unsigned SHORT_W   = 2;
  localparam int unsigned DEST_W    = 8;
  // field positions in the command register
  localparam int unsigned VEC_LSB   = 0;
  localparam int unsigned DMODE_LSB = 8;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned SHORT_LSB = 18;
  localparam int unsigned DEST_LSB  = 24;

  typedef enum logic [SHORT_W-1:0] {
    SH_NONE     = 2'b00,
    SH_SELF     = 2'b01,
    SH_ALL_INC  = 2'b10,
    SH_ALL_EXC  = 2'b11
  } short_e;

  localparam logic [DMODE_W-1:0] DM_FIXED = 3'b000;
  localparam logic               TRIG_EDGE = 1'b0;

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DMODE_W-1:0] dmode;
    logic               trig;
    short_e             short_sel;
    logic [DEST_W-1:0]  dest;
  } ipi_msg_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              launch_o,
  output ipi_msg_t          msg_o
);
  localparam logic ADDR_LO = 1'b0;
  localparam logic ADDR_HI = 1'b1;

  logic [DEST_W-1:0] hi_dest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hi_dest_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_HI)
      hi_dest_q <= wr_data_i[DEST_LSB +: DEST_W];
  end

  short_e short_w;
  assign short_w = short_e'(wr_data_i[SHORT_LSB +: SHORT_W]);

  always_comb begin
    launch_o        = wr_en_i && (wr_addr_i == ADDR_LO);
    msg_o.vector    = wr_data_i[VEC_LSB +: VEC_W];
    msg_o.dmode     = wr_data_i[DMODE_LSB +: DMODE_W];
    msg_o.trig      = wr_data_i[TRIG_BIT];
    msg_o.short_sel = short_w;
    // destination only meaningful without shorthand
    msg_o.dest      = (short_w == SH_NONE) ? hi_dest_q : '0;
  end
endmodule

// File: rtl/ipi_self_decode.sv
module ipi_self_decode
  import ipi_pkg::*;
(
  input  logic              self_we_i,
  input  logic [DATA_W-1:0] self_data_i,
  output logic              launch_o,
  output ipi_msg_t          msg_o
);
  always_comb begin
    launch_o        = self_we_i;
    msg_o.vector    = self_data_i[VEC_W-1:0];
    msg_o.dmode     = DM_FIXED;
    msg_o.trig      = TRIG_EDGE;
    msg_o.short_sel = SH_SELF;
    msg_o.dest      = '0;
  end
endmodule

// File: rtl/ipi_launch_arb.sv
module ipi_launch_arb
  import ipi_pkg::*;
(
  input  logic     cmd_launch_i,
  input  ipi_msg_t cmd_msg_i,
  input  logic     self_launch_i,
  input  ipi_msg_t self_msg_i,
  output logic     launch_o,
  output ipi_msg_t msg_o
);
  // command port wins; a losing self write is discarded silently
  always_comb begin
    launch_o = cmd_launch_i || self_launch_i;
    msg_o    = cmd_launch_i ? cmd_msg_i : self_msg_i;
  end
endmodule

// File: rtl/ipi_msg_hold.sv
module ipi_msg_hold
  import ipi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     launch_i,
  input  ipi_msg_t msg_i,
  input  logic     ready_i,
  output logic     valid_o,
  output ipi_msg_t msg_o,
  output logic     err_o
);
  logic     valid_q;
  logic     err_q;
  ipi_msg_t msg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (launch_i && !valid_q) begin
      valid_q <= 1'b1;
      msg_q   <= msg_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   err_q <= 1'b0;
    else if (launch_i && valid_q)  err_q <= 1'b1;
  end

  assign valid_o = valid_q;
  assign msg_o   = msg_q;
  assign err_o   = err_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(msg_o));
  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> !valid_o);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R7
  drop_sets_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && valid_o |=> err_o);
endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
  import ipi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic        self_we_i,
  input  logic [31:0] self_data_i,
  output logic        msg_valid_o,
  input  logic        msg_ready_i,
  output logic [7:0]  msg_vector_o,
  output logic [2:0]  msg_dmode_o,
  output logic        msg_trig_o,
  output logic [1:0]  msg_short_o,
  output logic [7:0]  msg_dest_o,
  output logic        busy_o,
  output logic        err_o
);
  logic     cmd_launch, self_launch, launch;
  ipi_msg_t cmd_msg, self_msg, arb_msg, out_msg;

  ipi_cmd_decode u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .launch_o(cmd_launch), .msg_o(cmd_msg));

  ipi_self_decode u_self (
    .self_we_i(self_we_i), .self_data_i(self_data_i),
    .launch_o(self_launch), .msg_o(self_msg));

  ipi_launch_arb u_arb (
    .cmd_launch_i(cmd_launch), .cmd_msg_i(cmd_msg),
    .self_launch_i(self_launch), .self_msg_i(self_msg),
    .launch_o(launch), .msg_o(arb_msg));

  ipi_msg_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .msg_i(arb_msg),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o), .msg_o(out_msg), .err_o(err_o));

  assign msg_vector_o = out_msg.vector;
  assign msg_dmode_o  = out_msg.dmode;
  assign msg_trig_o   = out_msg.trig;
  assign msg_short_o  = out_msg.short_sel;
  assign msg_dest_o   = out_msg.dest;
  assign busy_o       = msg_valid_o;

  // R2
  cmd_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_addr_i && !msg_valid_o |=>
      msg_valid_o && msg_vector_o == $past(wr_data_i[7:0])
      && msg_short_o == $past(wr_data_i[19:18]));
  // R5
  self_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_we_i && !(wr_en_i && !wr_addr_i) && !msg_valid_o |=>
      msg_valid_o && msg_short_o == 2'b01 && !msg_trig_o
      && msg_dmode_o == 3'b000 && msg_dest_o == 8'h00
      && msg_vector_o == $past(self_data_i[7:0]));
  // R3
  hi_no_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i && !self_we_i && !msg_valid_o |=> !msg_valid_o);
  // R4
  dest_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_short_o != 2'b00 |-> msg_dest_o == 8'h00);
  // R8
  cmd_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_addr_i && self_we_i && !msg_valid_o |=>
      msg_vector_o == $past(wr_data_i[7:0]) && err_o == $past(err_o));
endmodule

// File: tb/ipi_cmd_issuer_tb.sv
module ipi_cmd_issuer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_addr_i = 1'b0, self_we_i = 1'b0;
  logic [31:0] wr_data_i = '0, self_data_i = '0;
  logic        msg_ready_i = 1'b0;
  logic        msg_valid_o, msg_trig_o, busy_o, err_o;
  logic [7:0]  msg_vector_o, msg_dest_o;
  logic [2:0]  msg_dmode_o;
  logic [1:0]  msg_short_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0]  hi_dest = 8'h00;
  logic [22:0] expq[$];  // {vector, dmode, trig, short, dest}

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ipi_cmd_issuer dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] cmd_exp(logic [31:0] d);
    logic [1:0] sh = d[19:18];
    return {d[7:0], d[10:8], d[15], sh, (sh == 2'b00) ? hi_dest : 8'h00};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // drivers: one-cycle strobes, expectation pushed when the launch is taken
  task automatic wr_hi(logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = 1; wr_data_i = d;
    hi_dest = d[31:24];
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic wr_lo(logic [31:0] d, bit taken);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = 0; wr_data_i = d;
    if (taken) expq.push_back(cmd_exp(d));
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic wr_self(logic [31:0] d, bit taken);
    @(negedge clk_i); self_we_i = 1; self_data_i = d;
    if (taken) expq.push_back({d[7:0], 3'b000, 1'b0, 2'b01, 8'h00});
    @(negedge clk_i); self_we_i = 0;
  endtask

  // monitor: between edges, valid&&ready means a handshake at the next edge
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !done && msg_valid_o && msg_ready_i) begin
      logic [22:0] got;
      got = {msg_vector_o, msg_dmode_o, msg_trig_o, msg_short_o, msg_dest_o};
      if (expq.size() == 0) chk("R2/R7 unexpected message", {9'h0, got}, 32'hDEAD);
      else chk("R2/R4/R5 message", {9'h0, got}, {9'h0, expq.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    #2;
    // R1 reset state
    chk("R1 valid", msg_valid_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 err", err_o, 0);
    @(negedge clk_i); rst_ni = 1; msg_ready_i = 1;
    idle(2);

    // R3 high-word write alone launches nothing
    wr_hi(32'h5A00_1234);
    #2; chk("R3 no launch", msg_valid_o, 0);
    idle(1); #2; chk("R3 no launch later", msg_valid_o, 0);

    // R2/R4 shorthand none uses stored destination
    wr_lo(32'h0000_0031, 1); idle(3);
    // R4 shorthand self, all-incl, all-excl force dest 0; other modes and level trigger
    wr_lo(32'h0004_8542, 1); idle(3);
    wr_lo(32'h0008_0463, 1); idle(3);
    wr_lo(32'hFFFF_FFFF, 1); idle(3);
    wr_hi(32'hC300_0000);
    wr_lo(32'h0000_8705, 1); idle(3);

    // R5 self register ignores upper bits
    wr_self(32'hFFFF_FF47, 1); idle(3);
    wr_self(32'h0000_00E0, 1); idle(3);

    // R8 same-cycle collision: command wins, no error
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = 0; wr_data_i = 32'h0000_0099;
    self_we_i = 1; self_data_i = 32'h0000_0011;
    expq.push_back(cmd_exp(32'h0000_0099));
    @(negedge clk_i); wr_en_i = 0; self_we_i = 0;
    idle(3); #2;
    chk("R8 err clear", err_o, 0);
    chk("R8 self dropped", expq.size(), 0);

    // R6/R7 back-pressure, drop, sticky error
    msg_ready_i = 0;
    wr_lo(32'h0000_00A1, 1);
    #2; chk("R7 busy", busy_o, 1);
    wr_self(32'h0000_00B2, 0);
    #2; chk("R7 err set", err_o, 1);
    idle(4); #2;
    chk("R6 valid held", msg_valid_o, 1);
    chk("R6 vector held", msg_vector_o, 8'hA1);
    @(negedge clk_i); msg_ready_i = 1;
    // launch during handshake cycle is dropped too (R7)
    wr_en_i = 1; wr_addr_i = 0; wr_data_i = 32'h0000_00C3;
    @(negedge clk_i); wr_en_i = 0;
    #2; chk("R6 released", msg_valid_o, 0);
    idle(3); #2;
    chk("R7 err sticky", err_o, 1);
    chk("R7 busy clear", busy_o, 0);
    chk("R7 queue drained", expq.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule